// File: doc/BRIEF.md
# Half-Bridge Overcurrent Qualifier and Response Controller

This block turns the raw overcurrent comparator bits of a set of half-bridges (four by default) into shutdown requests and status flags. Each bridge has its own qualifier state machine. After a switching event on that bridge, the qualifier ignores its comparator for a programmable blanking time. Once blanking has elapsed, a comparator that stays high without a break for a programmable deglitch time is reported as one detection. All timing counts a single-cycle tick enable that marks 1 µs.

A shared response stage handles each detection according to a two-bit monitor mode:
- **Latched:** a fault flag is set and held.
- **Cycle-by-cycle:** the bridge is shut down until its next PWM cycle-start strobe, and a sticky flag records the event.
- **Warning:** only a warning flag is set.
- **Disabled:** nothing is reported.

A shutdown either stays on the bridge that tripped or is spread to every bridge, depending on an independent-shutdown input. A clear strobe erases the reported flags.

Qualifier states and transitions (per bridge):
- **Q_ARMED:** watches the comparator. A high comparator takes it to Q_QUAL with the counter at zero.
- **Q_BLANK:** counts ticks with the comparator ignored, then returns to Q_ARMED when the blanking time has elapsed.
- **Q_QUAL:** counts ticks while the comparator stays high. A low comparator takes it back to Q_ARMED. Reaching the deglitch time raises a detection and moves to Q_HELD.
- **Q_HELD:** waits for the comparator to fall, then goes back to Q_ARMED. This gives one detection per high episode.

A switching event sends any state to Q_BLANK with the counter cleared. The state after reset is Q_ARMED.

Top module: `ocm_monitor`

## Requirements
- R1: After reset, every output (shutdown, fault, warning, cycle flag, global fault) is 0.
- R2: After a switching strobe on a bridge, that bridge's comparator is ignored for its blanking time. The blanking time is selected by a 3-bit code per bridge, with bridge b at bits [3b+2:3b]. Codes 0 to 7 give 2, 4, 8, 12, 16, 24, 32 and 96 ticks.
- R3: A detection needs the comparator to stay high continuously for the deglitch time. The deglitch time is selected by a 2-bit code per bridge, with bridge b at bits [2b+1:2b]. Codes 0 to 3 give 1, 2, 4 and 8 ticks. A shorter high pulse produces no report.
- R4: In mode 00 (latched), a detection sets the bridge's fault flag and requests shutdown, and both hold until a clear strobe.
- R5: In mode 01 (cycle-by-cycle), a detection sets the bridge's sticky cycle flag and requests shutdown. The shutdown is released only by that bridge's own cycle-start strobe. The sticky flag stays until a clear strobe.
- R6: In mode 10 (warning), a detection sets the bridge's warning flag and requests no shutdown.
- R7: In mode 11 (disabled), detections set no flag and request no shutdown.
- R8: With independent shutdown at 0, any bridge's active shutdown drives all shutdown outputs. With it at 1, only the affected bridge's output is driven.
- R9: The global fault output is high when any fault flag or cycle flag is set. Warnings do not raise it.
- R10: A clear strobe resets the fault, warning and cycle flags. A detection in the same cycle as the clear still sets its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | 1 µs timing enable, one cycle wide |
| cmp_i | input | NUM_BR | Raw overcurrent comparator, one bit per bridge |
| sw_evt_i | input | NUM_BR | Switching-event strobe per bridge; starts blanking |
| cyc_start_i | input | NUM_BR | PWM cycle-start strobe per bridge |
| mode_i | input | 2 | Monitor mode: 00 latched, 01 cycle-by-cycle, 10 warning, 11 disabled |
| indep_i | input | 1 | 1: shutdown limited to the affected bridge; 0: shutdown applies to all bridges |
| blank_sel_i | input | 3*NUM_BR | Blanking code per bridge |
| dg_sel_i | input | 2*NUM_BR | Deglitch code per bridge |
| clr_i | input | 1 | Clear-fault strobe |
| shdn_o | output | NUM_BR | Shutdown request per bridge |
| fault_o | output | NUM_BR | Latched fault flag per bridge |
| warn_o | output | NUM_BR | Warning flag per bridge |
| cyc_flag_o | output | NUM_BR | Sticky cycle-by-cycle event flag per bridge |
| any_fault_o | output | 1 | Global fault |

## Verification
Each fault of a qualifier state shows up at the ports as a flag that rises at the wrong time. A qualifier that leaves Q_BLANK early raises a flag for a comparator pulse placed inside the blanking window. A deglitch counter that is not cleared on a falling comparator lets a series of short pulses add up to a report. The flags are registered one cycle after the tick that completes qualification, so each error can be seen within one tick period of its cause. Errors in the response stage appear on the very next cycle: a shutdown spread or withheld wrongly, a cycle release taken from the wrong bridge, or a warning that raises the global fault.

// File: rtl/ocm_pkg.sv
package ocm_pkg;

    localparam int BLK_W = 3;   // blanking code width per bridge
    localparam int DG_W  = 2;   // deglitch code width per bridge
    localparam int TCK_W = 8;   // tick counter width, holds up to 96

    typedef enum logic [1:0] {
        MODE_LATCH = 2'b00,
        MODE_CYCLE = 2'b01,
        MODE_WARN  = 2'b10,
        MODE_OFF   = 2'b11
    } ocm_mode_e;

    typedef enum logic [1:0] {
        Q_ARMED = 2'b00,
        Q_BLANK = 2'b01,
        Q_QUAL  = 2'b10,
        Q_HELD  = 2'b11
    } qual_state_e;

    // Blanking length in ticks for a 3-bit code
    function automatic logic [TCK_W-1:0] blank_ticks(input logic [BLK_W-1:0] code);
        logic [TCK_W-1:0] t;
        unique case (code)
            3'd0:    t = 8'd2;
            3'd1:    t = 8'd4;
            3'd2:    t = 8'd8;
            3'd3:    t = 8'd12;
            3'd4:    t = 8'd16;
            3'd5:    t = 8'd24;
            3'd6:    t = 8'd32;
            default: t = 8'd96;
        endcase
        return t;
    endfunction

    // Deglitch length in ticks: 1, 2, 4, 8
    function automatic logic [TCK_W-1:0] dg_ticks(input logic [DG_W-1:0] code);
        return TCK_W'(1) << code;
    endfunction

endpackage

// File: rtl/ocm_qual.sv
module ocm_qual
    import ocm_pkg::*;
#(
    parameter int CNT_W = TCK_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             cmp_i,
    input  logic             sw_evt_i,
    input  logic [BLK_W-1:0] blank_sel_i,
    input  logic [DG_W-1:0]  dg_sel_i,
    output logic             detect_o
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    qual_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] blank_lim;
    logic [CNT_W-1:0] dg_lim;

    assign cnt_inc   = cnt_q + CNT_ONE;
    assign blank_lim = CNT_W'(blank_ticks(blank_sel_i));
    assign dg_lim    = CNT_W'(dg_ticks(dg_sel_i));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= Q_ARMED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state, counter and detection pulse
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        detect_o = 1'b0;
        if (sw_evt_i) begin
            state_d = Q_BLANK;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                Q_BLANK: begin
                    if (tick_i) begin
                        if (cnt_inc >= blank_lim) begin
                            state_d = Q_ARMED;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_inc;
                        end
                    end
                end
                Q_ARMED: begin
                    if (cmp_i) begin
                        state_d = Q_QUAL;
                        cnt_d   = '0;
                    end
                end
                Q_QUAL: begin
                    if (!cmp_i) begin
                        state_d = Q_ARMED;
                    end else if (tick_i) begin
                        if (cnt_inc >= dg_lim) begin
                            state_d  = Q_HELD;
                            detect_o = 1'b1;
                        end else begin
                            cnt_d = cnt_inc;
                        end
                    end
                end
                Q_HELD: begin
                    if (!cmp_i) begin
                        state_d = Q_ARMED;
                    end
                end
                default: state_d = Q_ARMED;
            endcase
        end
    end

endmodule

// File: rtl/ocm_resp.sv
module ocm_resp
    import ocm_pkg::*;
#(
    parameter int NUM_BR = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_BR-1:0] detect_i,
    input  logic [1:0]        mode_i,
    input  logic              indep_i,
    input  logic [NUM_BR-1:0] cyc_start_i,
    input  logic              clr_i,
    output logic [NUM_BR-1:0] shdn_o,
    output logic [NUM_BR-1:0] fault_o,
    output logic [NUM_BR-1:0] warn_o,
    output logic [NUM_BR-1:0] cyc_flag_o,
    output logic              any_fault_o
);

    ocm_mode_e         mode_e;
    logic [NUM_BR-1:0] fault_q, warn_q, cyc_q, cut_q;
    logic [NUM_BR-1:0] set_fault, set_warn, set_cyc;
    logic [NUM_BR-1:0] keep_mask;
    logic [NUM_BR-1:0] active;

    assign mode_e    = ocm_mode_e'(mode_i);
    assign keep_mask = clr_i ? '0 : '1;

    // Route detections by mode
    always_comb begin
        set_fault = '0;
        set_warn  = '0;
        set_cyc   = '0;
        unique case (mode_e)
            MODE_LATCH: set_fault = detect_i;
            MODE_CYCLE: set_cyc   = detect_i;
            MODE_WARN:  set_warn  = detect_i;
            MODE_OFF:   ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_q <= '0;
            warn_q  <= '0;
            cyc_q   <= '0;
            cut_q   <= '0;
        end else begin
            fault_q <= (fault_q & keep_mask) | set_fault;
            warn_q  <= (warn_q  & keep_mask) | set_warn;
            cyc_q   <= (cyc_q   & keep_mask) | set_cyc;
            cut_q   <= (cut_q & ~cyc_start_i) | set_cyc;
        end
    end

    // Outputs
    always_comb begin
        active      = fault_q | cut_q;
        shdn_o      = indep_i ? active : {NUM_BR{|active}};
        fault_o     = fault_q;
        warn_o      = warn_q;
        cyc_flag_o  = cyc_q;
        any_fault_o = (|fault_q) | (|cyc_q);
    end

endmodule

// File: rtl/ocm_monitor.sv
module ocm_monitor
    import ocm_pkg::*;
#(
    parameter int NUM_BR = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick_i,
    input  logic [NUM_BR-1:0]       cmp_i,
    input  logic [NUM_BR-1:0]       sw_evt_i,
    input  logic [NUM_BR-1:0]       cyc_start_i,
    input  logic [1:0]              mode_i,
    input  logic                    indep_i,
    input  logic [NUM_BR*BLK_W-1:0] blank_sel_i,
    input  logic [NUM_BR*DG_W-1:0]  dg_sel_i,
    input  logic                    clr_i,
    output logic [NUM_BR-1:0]       shdn_o,
    output logic [NUM_BR-1:0]       fault_o,
    output logic [NUM_BR-1:0]       warn_o,
    output logic [NUM_BR-1:0]       cyc_flag_o,
    output logic                    any_fault_o
);

    logic [NUM_BR-1:0] detect;

    for (genvar b = 0; b < NUM_BR; b++) begin : g_br
        ocm_qual #(.CNT_W(TCK_W)) u_qual (
            .clk         (clk),
            .rst_n       (rst_n),
            .tick_i      (tick_i),
            .cmp_i       (cmp_i[b]),
            .sw_evt_i    (sw_evt_i[b]),
            .blank_sel_i (blank_sel_i[b*BLK_W +: BLK_W]),
            .dg_sel_i    (dg_sel_i[b*DG_W +: DG_W]),
            .detect_o    (detect[b])
        );
    end

    ocm_resp #(.NUM_BR(NUM_BR)) u_resp (
        .clk         (clk),
        .rst_n       (rst_n),
        .detect_i    (detect),
        .mode_i      (mode_i),
        .indep_i     (indep_i),
        .cyc_start_i (cyc_start_i),
        .clr_i       (clr_i),
        .shdn_o      (shdn_o),
        .fault_o     (fault_o),
        .warn_o      (warn_o),
        .cyc_flag_o  (cyc_flag_o),
        .any_fault_o (any_fault_o)
    );

endmodule

// File: rtl/ocm_monitor_chk.sv
module ocm_monitor_chk #(
    parameter int NUM_BR = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_BR-1:0] sw_evt_i,
    input logic [1:0]        mode_i,
    input logic              indep_i,
    input logic              clr_i,
    input logic [NUM_BR-1:0] shdn_o,
    input logic [NUM_BR-1:0] fault_o,
    input logic [NUM_BR-1:0] warn_o,
    input logic [NUM_BR-1:0] cyc_flag_o,
    input logic              any_fault_o
);

    logic [NUM_BR-1:0] flags;
    assign flags = fault_o | warn_o | cyc_flag_o;

    // R4
    latched_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((fault_o & $past(fault_o)) == $past(fault_o)));

    // R8
    shared_shdn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!indep_i && (fault_o != '0)) |-> (shdn_o == '1));

    // R8
    own_shdn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        indep_i |-> ((fault_o & ~shdn_o) == '0));

    // R7
    off_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b11) |=> ((flags & ~$past(flags)) == '0));

    // R2
    blank_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & ~$past(flags) & $past(sw_evt_i)) == '0));

    // R9
    warn_not_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((fault_o == '0) && (cyc_flag_o == '0)) |-> !any_fault_o);

endmodule

bind ocm_monitor ocm_monitor_chk #(.NUM_BR(NUM_BR)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_evt_i    (sw_evt_i),
    .mode_i      (mode_i),
    .indep_i     (indep_i),
    .clr_i       (clr_i),
    .shdn_o      (shdn_o),
    .fault_o     (fault_o),
    .warn_o      (warn_o),
    .cyc_flag_o  (cyc_flag_o),
    .any_fault_o (any_fault_o)
);

// File: tb/ocm_monitor_tb.sv
`timescale 1ns/1ps
module ocm_monitor_tb;

    localparam int NB = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_i = 1'b0;
    logic [NB-1:0] cmp_i = '0;
    logic [NB-1:0] sw_evt_i = '0;
    logic [NB-1:0] cyc_start_i = '0;
    logic [1:0]    mode_i = 2'b00;
    logic          indep_i = 1'b1;
    logic [11:0]   blank_sel_i = '0;
    logic [7:0]    dg_sel_i = 8'b00_00_00_10;
    logic          clr_i = 1'b0;
    logic [NB-1:0] shdn_o, fault_o, warn_o, cyc_flag_o;
    logic          any_fault_o;

    ocm_monitor #(.NUM_BR(NB)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cmp_i(cmp_i),
        .sw_evt_i(sw_evt_i), .cyc_start_i(cyc_start_i), .mode_i(mode_i),
        .indep_i(indep_i), .blank_sel_i(blank_sel_i), .dg_sel_i(dg_sel_i),
        .clr_i(clr_i), .shdn_o(shdn_o), .fault_o(fault_o), .warn_o(warn_o),
        .cyc_flag_o(cyc_flag_o), .any_fault_o(any_fault_o)
    );

    always #4 clk = ~clk;

    typedef struct {
        string       tag;
        logic [16:0] exp;
    } sb_item_t;

    sb_item_t sb_q[$];
    event     smp;
    int       n_vec = 0;
    int       n_bad = 0;
    bit       done = 1'b0;
    bit       reported = 1'b0;

    // Tick enable: one cycle in four
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            tick_i = 1'b1;
            @(negedge clk);
            tick_i = 1'b0;
        end
    end

    function automatic logic [16:0] mk(input logic any, input logic [3:0] cyc,
                                       input logic [3:0] wrn, input logic [3:0] flt,
                                       input logic [3:0] sd);
        return {any, cyc, wrn, flt, sd};
    endfunction

    // Driver side: push expected item, wake the monitor
    task automatic expect_out(input string tag, input logic [16:0] exp);
        sb_item_t it;
        it.tag = tag;
        it.exp = exp;
        sb_q.push_back(it);
        -> smp;
        #1;
    endtask

    // Monitor: compare outputs against queued items
    initial begin
        forever begin
            @(smp);
            while (sb_q.size() > 0) begin
                sb_item_t it;
                logic [16:0] got;
                it  = sb_q.pop_front();
                got = {any_fault_o, cyc_flag_o, warn_o, fault_o, shdn_o};
                n_vec++;
                if (got !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual %b expected %b", it.tag, got, it.exp);
                end
            end
        end
    end

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_flags();
        clr_i = 1'b1;
        hold(1);
        clr_i = 1'b0;
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        hold(3);
        expect_out("R1 outputs in reset", 17'h0);
        rst_n = 1'b1;
        hold(2);
        expect_out("R1 outputs after reset", 17'h0);

        // R3: bridge 0, deglitch 4 ticks, latched, independent
        cmp_i[0] = 1'b1; hold(8); cmp_i[0] = 1'b0; hold(4);
        expect_out("R3 short glitch ignored", 17'h0);
        cmp_i[0] = 1'b1; hold(12); cmp_i[0] = 1'b0; hold(4);
        expect_out("R3 pulse of deglitch minus one ignored", 17'h0);
        cmp_i[0] = 1'b1; hold(24);
        expect_out("R3 R4 R8 sustained fault latched on own bridge",
                   mk(1'b1, 4'h0, 4'h0, 4'h1, 4'h1));
        cmp_i[0] = 1'b0; hold(20);
        expect_out("R4 latched after comparator low",
                   mk(1'b1, 4'h0, 4'h0, 4'h1, 4'h1));
        clear_flags();
        expect_out("R10 clear resets flags", 17'h0);

        // R8: shared shutdown
        indep_i = 1'b0;
        cmp_i[2] = 1'b1; hold(12); cmp_i[2] = 1'b0; hold(2);
        expect_out("R8 shared shutdown on all bridges",
                   mk(1'b1, 4'h0, 4'h0, 4'h4, 4'hF));
        clear_flags();
        expect_out("R10 clear after shared fault", 17'h0);
        indep_i = 1'b1;

        // R2: bridge 1 blanking code 001 (4 ticks)
        blank_sel_i[5:3] = 3'b001;
        sw_evt_i[1] = 1'b1; cmp_i[1] = 1'b1; hold(1);
        sw_evt_i[1] = 1'b0; hold(11);
        cmp_i[1] = 1'b0; hold(2);
        expect_out("R2 comparator ignored in blanking", 17'h0);
        hold(40);
        cmp_i[1] = 1'b1; hold(12); cmp_i[1] = 1'b0; hold(2);
        expect_out("R2 fault after blanking elapsed",
                   mk(1'b1, 4'h0, 4'h0, 4'h2, 4'h2));
        clear_flags();

        // R2: bridge 3 blanking code 111 (96 ticks)
        blank_sel_i[11:9] = 3'b111;
        sw_evt_i[3] = 1'b1; cmp_i[3] = 1'b1; hold(1);
        sw_evt_i[3] = 1'b0; hold(359);
        expect_out("R2 longest blanking still active", 17'h0);
        hold(60);
        expect_out("R2 longest blanking then fault",
                   mk(1'b1, 4'h0, 4'h0, 4'h8, 4'h8));
        cmp_i[3] = 1'b0;
        clear_flags();
        expect_out("R10 clear after long blanking", 17'h0);

        // R5: cycle-by-cycle on bridge 0 (deglitch 4 ticks)
        mode_i = 2'b01;
        cmp_i[0] = 1'b1; hold(30); cmp_i[0] = 1'b0; hold(2);
        expect_out("R5 cycle mode shuts down bridge",
                   mk(1'b1, 4'h1, 4'h0, 4'h0, 4'h1));
        cyc_start_i[1] = 1'b1; hold(1); cyc_start_i[1] = 1'b0; hold(1);
        expect_out("R5 other bridge cycle start no release",
                   mk(1'b1, 4'h1, 4'h0, 4'h0, 4'h1));
        cyc_start_i[0] = 1'b1; hold(1); cyc_start_i[0] = 1'b0; hold(1);
        expect_out("R5 own cycle start releases, flag sticky",
                   mk(1'b1, 4'h1, 4'h0, 4'h0, 4'h0));
        clear_flags();
        expect_out("R10 clear removes cycle flag", 17'h0);

        // R6 / R9: warning on bridge 2
        mode_i = 2'b10;
        cmp_i[2] = 1'b1; hold(12); cmp_i[2] = 1'b0; hold(2);
        expect_out("R6 R9 warning only, no shutdown, no global",
                   mk(1'b0, 4'h0, 4'h4, 4'h0, 4'h0));
        clear_flags();
        expect_out("R10 clear removes warning", 17'h0);

        // R7: disabled
        mode_i = 2'b11;
        cmp_i = 4'hF; hold(40);
        expect_out("R7 disabled mode reports nothing", 17'h0);
        cmp_i = 4'h0; hold(2);
        mode_i = 2'b00;

        hold(2);
        done = 1'b1;
        report();
        $finish;
    end

endmodule